// File: doc/BRIEF.md
# Segmented Commit Log Manager

This block sits beside a main execution pipeline and steers its committed memory records into a log that is cut into equal segments. Every segment is tied to exactly one checker unit. Records are written into the currently open segment in the order the pipeline commits them, so a checker can later walk its segment from start to end. The block decides when the open segment is sealed. It asks for a register checkpoint at that boundary and, once the checkpoint is acknowledged, starts the checker that owns the sealed segment. It then opens the next free segment. A segment becomes free again only when its checker reports completion. While no segment is free, or while a checkpoint is in progress, the producer is held off by a stall output.

A segment is sealed at an instruction boundary for one of three reasons. The remaining room may be smaller than the most records one instruction can emit, so no instruction is split across segments. The number of instructions retired into the segment may have reached a programmable limit, which guards against a producer that loops without touching memory. An interrupt or context switch may force the boundary. At launch the checker receives the segment's record count and instruction count. The block computes log write addresses, but the log storage, the checkpoint storage and the checkers themselves are outside it.

Top module: `seglog_mgr`

## Requirements
- R1: After reset, segment 0 is open, `stall` is low, `ckpt_req` is low, and no `chk_start` bit is set.
- R2: Each accepted record asserts `log_wr_en` in the same cycle, with `log_wr_addr` = open segment index × SEG_ENTRIES + records already in that segment.
- R3: A cycle with `cmt_retire` seals the open segment when SEG_ENTRIES minus the record count (this cycle's record included) is below MAX_MACRO. A record without `cmt_retire` never seals, even when the room is below that level.
- R4: A cycle with `cmt_retire` seals the open segment when its retired-instruction count (this cycle included) reaches `max_insn`.
- R5: An accepted cycle with `cmt_irq` seals the open segment, counting that cycle's record and retire.
- R6: In the cycle after a seal, `ckpt_req` is high with `ckpt_seg` naming the sealed segment. `ckpt_req` and `stall` stay high until `ckpt_ack` is seen.
- R7: In the cycle after `ckpt_ack`, the sealed segment's `chk_start` bit pulses for one cycle, with `chk_entries` and `chk_insns` giving its record and instruction counts. The lowest-index free segment opens at that same edge.
- R8: A `chk_done` pulse frees its segment only if that segment is under check. A pulse for a segment being filled has no effect.
- R9: When every segment is sealed or under check, `stall` stays high until a `chk_done` frees one. The lowest-index free segment then opens and `stall` drops.
- R10: Commit inputs presented while `stall` is high are ignored: they cause no writes and do not change any count.
- R11: A segment that is being filled never has its `chk_start` bit asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmt_rec_valid | input | 1 | A memory record is committed this cycle |
| cmt_rec_data | input | DW | Record payload |
| cmt_retire | input | 1 | An architectural instruction completes this cycle (boundary) |
| cmt_irq | input | 1 | Interrupt or context-switch boundary this cycle |
| max_insn | input | ICW | Instruction-count limit per segment |
| ckpt_ack | input | 1 | Checkpoint taken |
| chk_done | input | NSEG | Per-segment check-complete pulses |
| stall | output | 1 | Producer must hold off |
| log_wr_en | output | 1 | Log write strobe |
| log_wr_addr | output | $clog2(NSEG*SEG_ENTRIES) | Log write address |
| log_wr_data | output | DW | Log write data |
| ckpt_req | output | 1 | Checkpoint request |
| ckpt_seg | output | $clog2(NSEG) | Segment sealed by the pending checkpoint |
| chk_start | output | NSEG | Per-segment check start pulses |
| chk_entries | output | $clog2(SEG_ENTRIES+1) | Record count of the launched segment |
| chk_insns | output | ICW | Instruction count of the launched segment |

## Verification
The seal decision is driven with four distinct patterns. One is a record on every retire, which reaches the room threshold. One is retire-only traffic against a small `max_insn`, which reaches the count limit with zero records. One is multi-record instructions, where the threshold is crossed by a record without a retire, which separates boundary-gated sealing from plain fill checks. The last is an interrupt on a nearly empty segment. Filling all segments shows the allocation order and the stall held until a completion. Stray completions and commits during stall show that neither one changes the state seen at the ports.

// File: rtl/seglog_pkg.sv
package seglog_pkg;
  typedef enum logic [1:0] {
    SEG_FREE  = 2'd0,
    SEG_FILL  = 2'd1,
    SEG_WAIT  = 2'd2,
    SEG_CHECK = 2'd3
  } seg_state_e;
endpackage

// File: rtl/seglog_slot.sv
module seglog_slot
  import seglog_pkg::*;
#(
  parameter bit OPEN_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic seal_i,
  input  logic launch_i,
  input  logic done_i,
  output logic is_free_o,
  output logic is_fill_o,
  output logic start_o
);
  seg_state_e state_q, state_d;
  logic       start_q, start_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEG_FREE:  if (open_i)   state_d = SEG_FILL;
      SEG_FILL:  if (seal_i)   state_d = SEG_WAIT;
      SEG_WAIT:  if (launch_i) state_d = SEG_CHECK;
      SEG_CHECK: if (done_i)   state_d = SEG_FREE;
      default:                 state_d = SEG_FREE;
    endcase
    start_d = (state_q == SEG_WAIT) && launch_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OPEN_AT_RESET ? SEG_FILL : SEG_FREE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign is_free_o = (state_q == SEG_FREE);
  assign is_fill_o = (state_q == SEG_FILL);
  assign start_o   = start_q;

  // R11: a filling segment never shows a start pulse
  p_fill_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEG_FILL) |-> !start_o);
  // R7: a start pulse coincides with the segment being under check
  p_start_in_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (state_q == SEG_CHECK));
  // R8: a check is only left through a done pulse
  p_check_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEG_CHECK && !done_i) |=> (state_q == SEG_CHECK));
endmodule

// File: rtl/seglog_pick.sv
module seglog_pick #(
  parameter int N = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  free_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |free_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/seglog_fill.sv
module seglog_fill #(
  parameter int ENTRIES   = 192,
  parameter int MAX_MACRO = 8,
  parameter int ICW       = 16,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           accept_i,
  input  logic           rec_i,
  input  logic           retire_i,
  input  logic           irq_i,
  input  logic [ICW-1:0] max_insn_i,
  output logic           seal_o,
  output logic [CW-1:0]  cnt_o,
  output logic [CW-1:0]  cnt_nx_o,
  output logic [ICW-1:0] icnt_nx_o
);
  logic [CW-1:0]  cnt_q, cnt_d, cnt_nx, room;
  logic [ICW-1:0] icnt_q, icnt_d, icnt_nx;
  logic           low_room, at_limit;

  always_comb begin
    cnt_nx   = cnt_q + CW'(rec_i);
    icnt_nx  = icnt_q + ICW'(retire_i);
    room     = CW'(ENTRIES) - cnt_nx;
    low_room = room < CW'(MAX_MACRO);
    at_limit = icnt_nx >= max_insn_i;
    seal_o   = accept_i && (irq_i || (retire_i && (low_room || at_limit)));
    cnt_d    = cnt_q;
    icnt_d   = icnt_q;
    if (clear_i) begin
      cnt_d  = '0;
      icnt_d = '0;
    end else if (accept_i) begin
      cnt_d  = cnt_nx;
      icnt_d = icnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      icnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      icnt_q <= icnt_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nx_o  = cnt_nx;
  assign icnt_nx_o = icnt_nx;

  // R3: the record count never runs past the segment size
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(ENTRIES));
endmodule

// File: rtl/seglog_mgr.sv
module seglog_mgr #(
  parameter int NSEG        = 12,
  parameter int SEG_ENTRIES = 192,
  parameter int MAX_MACRO   = 8,
  parameter int ICW         = 16,
  parameter int DW          = 64,
  localparam int IW = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int CW = $clog2(SEG_ENTRIES + 1),
  localparam int AW = $clog2(NSEG * SEG_ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmt_rec_valid,
  input  logic [DW-1:0]   cmt_rec_data,
  input  logic            cmt_retire,
  input  logic            cmt_irq,
  input  logic [ICW-1:0]  max_insn,
  input  logic            ckpt_ack,
  input  logic [NSEG-1:0] chk_done,
  output logic            stall,
  output logic            log_wr_en,
  output logic [AW-1:0]   log_wr_addr,
  output logic [DW-1:0]   log_wr_data,
  output logic            ckpt_req,
  output logic [IW-1:0]   ckpt_seg,
  output logic [NSEG-1:0] chk_start,
  output logic [CW-1:0]   chk_entries,
  output logic [ICW-1:0]  chk_insns
);
  logic            have_open_q, have_open_d;
  logic [IW-1:0]   cur_q, cur_d;
  logic            req_q, req_d;
  logic [IW-1:0]   ck_seg_q, ck_seg_d;
  logic [CW-1:0]   lat_cnt_q, lat_cnt_d;
  logic [ICW-1:0]  lat_icnt_q, lat_icnt_d;

  logic            accept, seal, launch, open_now, any_free;
  logic [IW-1:0]   pick_idx;
  logic [NSEG-1:0] free_vec, fill_vec;
  logic [CW-1:0]   cnt_cur, cnt_nx;
  logic [ICW-1:0]  icnt_nx;

  assign stall    = !have_open_q || req_q;
  assign accept   = !stall;
  assign launch   = req_q && ckpt_ack;
  assign open_now = !have_open_q && (!req_q || ckpt_ack) && any_free;

  seglog_fill #(
    .ENTRIES  (SEG_ENTRIES),
    .MAX_MACRO(MAX_MACRO),
    .ICW      (ICW)
  ) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (open_now),
    .accept_i  (accept),
    .rec_i     (cmt_rec_valid),
    .retire_i  (cmt_retire),
    .irq_i     (cmt_irq),
    .max_insn_i(max_insn),
    .seal_o    (seal),
    .cnt_o     (cnt_cur),
    .cnt_nx_o  (cnt_nx),
    .icnt_nx_o (icnt_nx)
  );

  seglog_pick #(.N(NSEG)) u_pick (
    .free_i(free_vec),
    .any_o (any_free),
    .idx_o (pick_idx)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    seglog_slot #(.OPEN_AT_RESET(g == 0)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_i   (open_now && (pick_idx == IW'(g))),
      .seal_i   (seal && (cur_q == IW'(g))),
      .launch_i (launch && (ck_seg_q == IW'(g))),
      .done_i   (chk_done[g]),
      .is_free_o(free_vec[g]),
      .is_fill_o(fill_vec[g]),
      .start_o  (chk_start[g])
    );
  end

  always_comb begin
    have_open_d = have_open_q;
    cur_d       = cur_q;
    req_d       = req_q;
    ck_seg_d    = ck_seg_q;
    lat_cnt_d   = lat_cnt_q;
    lat_icnt_d  = lat_icnt_q;
    if (seal) begin
      have_open_d = 1'b0;
      req_d       = 1'b1;
      ck_seg_d    = cur_q;
      lat_cnt_d   = cnt_nx;
      lat_icnt_d  = icnt_nx;
    end else if (launch) begin
      req_d = 1'b0;
    end
    if (open_now) begin
      have_open_d = 1'b1;
      cur_d       = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_open_q <= 1'b1;
      cur_q       <= '0;
      req_q       <= 1'b0;
      ck_seg_q    <= '0;
      lat_cnt_q   <= '0;
      lat_icnt_q  <= '0;
    end else begin
      have_open_q <= have_open_d;
      cur_q       <= cur_d;
      req_q       <= req_d;
      ck_seg_q    <= ck_seg_d;
      lat_cnt_q   <= lat_cnt_d;
      lat_icnt_q  <= lat_icnt_d;
    end
  end

  assign log_wr_en   = accept && cmt_rec_valid;
  assign log_wr_addr = AW'(cur_q) * AW'(SEG_ENTRIES) + AW'(cnt_cur);
  assign log_wr_data = cmt_rec_data;
  assign ckpt_req    = req_q;
  assign ckpt_seg    = ck_seg_q;
  assign chk_entries = lat_cnt_q;
  assign chk_insns   = lat_icnt_q;

  // R6: a pending checkpoint request is held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_req && !ckpt_ack) |=> ckpt_req);
  // R11: at most one segment is being filled at a time
  p_one_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fill_vec) <= 1);
  // R7: at most one checker is launched per cycle
  p_one_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_start));
endmodule

// File: tb/seglog_mgr_tb.sv
module seglog_mgr_tb;
  localparam int NSEG = 4, SE = 16, MM = 4, ICW = 16, DW = 16;
  localparam int IW = 2, CW = 5, AW = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rec, ret, irq, ack;
  logic [DW-1:0]   data;
  logic [ICW-1:0]  max_insn;
  logic [NSEG-1:0] done;
  logic            stall, wr_en, req;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data;
  logic [IW-1:0]   ck_seg;
  logic [NSEG-1:0] start;
  logic [CW-1:0]   ent;
  logic [ICW-1:0]  ins;

  int total = 0;
  int bad   = 0;
  int cur_seg = 0;
  int cur_cnt = 0;

  always #5 clk = ~clk;

  seglog_mgr #(.NSEG(NSEG), .SEG_ENTRIES(SE), .MAX_MACRO(MM), .ICW(ICW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmt_rec_valid(rec), .cmt_rec_data(data),
    .cmt_retire(ret), .cmt_irq(irq), .max_insn(max_insn), .ckpt_ack(ack),
    .chk_done(done), .stall(stall), .log_wr_en(wr_en), .log_wr_addr(wr_addr),
    .log_wr_data(wr_data), .ckpt_req(req), .ckpt_seg(ck_seg), .chk_start(start),
    .chk_entries(ent), .chk_insns(ins)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic commit(input bit r, input bit t, input bit q);
    @(negedge clk);
    chk(stall == 1'b0, "R9 stall low before commit", int'(stall), 0);
    rec = r; ret = t; irq = q; data = DW'(16'hA500 + cur_cnt);
    #1;
    chk(wr_en == r, "R2 write strobe", int'(wr_en), int'(r));
    if (r) begin
      chk(int'(wr_addr) == cur_seg * SE + cur_cnt, "R2 write address",
          int'(wr_addr), cur_seg * SE + cur_cnt);
      chk(wr_data == data, "R2 write data", int'(wr_data), int'(data));
    end
    chk(start == '0, "R11 no start while filling", int'(start), 0);
    @(posedge clk);
    #1;
    rec = 0; ret = 0; irq = 0;
    if (r) cur_cnt++;
  endtask

  task automatic expect_seal(input int seg, input string tag);
    @(negedge clk);
    chk(req == 1'b1, {tag, " ckpt_req raised"}, int'(req), 1);
    chk(int'(ck_seg) == seg, "R6 ckpt_seg", int'(ck_seg), seg);
    chk(stall == 1'b1, "R6 stall during checkpoint", int'(stall), 1);
  endtask

  task automatic expect_no_seal(input string tag);
    @(negedge clk);
    chk(req == 1'b0, tag, int'(req), 0);
  endtask

  task automatic do_ack(input int seg, input int e, input int n, input bit free_after);
    repeat (15) @(negedge clk);
    chk(req == 1'b1 && stall == 1'b1, "R6 held until ack", int'(req), 1);
    ack = 1'b1;
    @(posedge clk);
    #1 ack = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R6 req drops after ack", int'(req), 0);
    chk(start == NSEG'(1 << seg), "R7 start pulse", int'(start), 1 << seg);
    chk(int'(ent) == e, "R7 launch entries", int'(ent), e);
    chk(int'(ins) == n, "R7 launch insns", int'(ins), n);
    chk(stall == !free_after, "R7 next segment opened", int'(stall), int'(!free_after));
    @(negedge clk);
    chk(start == '0, "R7 start is a single pulse", int'(start), 0);
    cur_cnt = 0;
  endtask

  task automatic pulse_done(input int seg);
    @(negedge clk);
    done = NSEG'(1 << seg);
    @(posedge clk);
    #1 done = '0;
  endtask

  task automatic wait_open(input int seg);
    int n = 0;
    while (stall && n < 5) begin
      @(negedge clk);
      n++;
    end
    chk(stall == 1'b0, "R9 stall released after done", int'(stall), 0);
    cur_seg = seg;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(stall == 1'b0, "R1 stall after reset", int'(stall), 0);
    chk(req == 1'b0, "R1 no ckpt_req after reset", int'(req), 0);
    chk(start == '0, "R1 no start after reset", int'(start), 0);
    chk(wr_en == 1'b0, "R1 no write after reset", int'(wr_en), 0);
  endtask

  task automatic t_fill;
    cur_seg = 0;
    for (int k = 0; k < 12; k++) commit(1, 1, 0);
    expect_no_seal("R3 no seal at room 4");
    commit(1, 1, 0);
    expect_seal(0, "R3");
    do_ack(0, 13, 13, 1'b1);
    cur_seg = 1;
  endtask

  task automatic t_timeout;
    max_insn = 16'd5;
    commit(0, 1, 0);
    pulse_done(1);
    @(negedge clk);
    chk(stall == 1'b0, "R8 done on filling segment ignored", int'(stall), 0);
    for (int k = 0; k < 3; k++) commit(0, 1, 0);
    expect_no_seal("R4 no seal below limit");
    commit(0, 1, 0);
    expect_seal(1, "R4");
    do_ack(1, 0, 5, 1'b1);
    cur_seg = 2;
    max_insn = 16'd100;
  endtask

  task automatic t_macro;
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 3; k++) commit(1, 0, 0);
      commit(1, 1, 0);
    end
    expect_no_seal("R3 no seal with room 4");
    commit(1, 0, 0);
    expect_no_seal("R3 no seal without boundary");
    commit(0, 1, 0);
    expect_seal(2, "R3");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rec = 1; ret = 1; irq = (k == 2);
      #1 chk(wr_en == 1'b0, "R10 no write while stalled", int'(wr_en), 0);
    end
    @(negedge clk);
    rec = 0; ret = 0; irq = 0;
    do_ack(2, 13, 4, 1'b1);
    cur_seg = 3;
  endtask

  task automatic t_irq_full;
    commit(1, 1, 0);
    commit(1, 1, 0);
    expect_no_seal("R5 no seal before interrupt");
    commit(1, 1, 1);
    expect_seal(3, "R5");
    do_ack(3, 3, 3, 1'b0);
    repeat (3) @(negedge clk);
    chk(stall == 1'b1, "R9 stall with all segments busy", int'(stall), 1);
    pulse_done(2);
    wait_open(2);
    commit(1, 1, 1);
    expect_seal(2, "R9 lowest free reopened");
    do_ack(2, 1, 1, 1'b0);
    pulse_done(0);
    wait_open(0);
    commit(1, 0, 1);
    expect_seal(0, "R9 lowest free reopened");
    do_ack(0, 1, 0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; rec = 0; ret = 0; irq = 0; ack = 0; data = '0;
    done = '0; max_insn = 16'd100;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_fill();
    t_timeout();
    t_macro();
    t_irq_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule